// File: doc/BRIEF.md
# SPI Word Master

This block is a single-channel SPI master that moves one 8-, 16- or 32-bit word at a time. It shifts data out on MOSI and in from MISO at the same time, drives SCK, and frames the word with one active-low chip select. The serial clock comes from two dividers in series on the system clock. A prescaler produces a tick every P system clocks. A period counter then spends C of those ticks on each SCK cycle, so SCK runs at the system clock divided by P times C.

Settings arrive on plain input pins. These are the clock polarity and phase, whether each byte goes out least significant bit first, whether multi-byte words go out most significant byte first, and a packed divider word. The block copies these settings into its own registers whenever it is idle. The readback outputs show the copied values, after clamping. A one-cycle `start` pulse begins a transfer of the selected width. `busy` covers the whole frame, and `done` pulses once when the received word is ready on `rx_word`.

Top module: `spi_word_master`

## Requirements
- R1: After reset, busy, done, spi_cs_n=0 inverted (spi_cs_n high), spi_sck, spi_mosi and rx_word are all low except spi_cs_n, which is high.
- R2: In cfg_div, bits 15:0 hold the prescaler P and bits 23:16 hold the count C. Each SCK cycle lasts P*C system clocks. The active phase (SCK away from its idle level) lasts P*(C/2) clocks, using integer division, and the idle-level phase lasts the rest of the cycle.
- R3: A prescaler field of 0 acts as 1, and a value above 8192 acts as 8192. A count field below 2 acts as 2, and a value above 64 acts as 64. rb_div reports the values in use, with the same field layout as cfg_div.
- R4: cfg_mode[1] is CPOL and cfg_mode[0] is CPHA, so the mode number is CPOL*2+CPHA. While idle, SCK rests at CPOL. rb_mode reports the mode number in use.
- R5: With CPHA=0, the first bit is on MOSI when the chip select falls. MISO is sampled on each leading SCK edge, and MOSI changes on each trailing edge. With CPHA=1, MOSI changes on each leading edge and MISO is sampled on each trailing edge.
- R6: With cfg_lsb_first=1, bit 0 of each byte is sent first. With cfg_lsb_first=0, bit 7 of each byte is sent first. The received bits are placed in the same order.
- R7: With cfg_big_endian=1, the most significant byte of a 16- or 32-bit word is sent first. With cfg_big_endian=0, the least significant byte is sent first. Received bytes are placed the same way. An 8-bit transfer is not affected by this setting.
- R8: The size input selects the transfer width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. Exactly that many SCK cycles occur, and all rx_word bits above the width read 0.
- R9: spi_cs_n falls on the clock edge that accepts start, and the first SCK edge follows P clocks later. spi_cs_n rises P clocks after the last SCK edge. done is a single-cycle pulse on that same edge, where busy falls.
- R10: A start pulse while busy is ignored. The transfer in progress is unchanged, and no second transfer follows it.
- R11: Changes on the configuration inputs during a transfer are ignored. The transfer keeps its timing and bit layout, and the readback outputs hold their values. The new settings take effect once the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Bit 1 CPOL, bit 0 CPHA |
| cfg_lsb_first | input | 1 | 1: least significant bit of each byte first |
| cfg_big_endian | input | 1 | 1: most significant byte first |
| cfg_div | input | 32 | Prescaler in 15:0, period count in 23:16 |
| start | input | 1 | Begin a transfer (taken only when idle) |
| size | input | 2 | 0: 8 bits, 1: 16 bits, 2/3: 32 bits |
| tx_word | input | 32 | Word to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | 32 | Word received in the latest transfer |
| rb_mode | output | 2 | Mode in use (CPOL*2+CPHA) |
| rb_lsb_first | output | 1 | Bit order in use |
| rb_big_endian | output | 1 | Byte order in use |
| rb_div | output | 32 | Clamped prescaler and count in use |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The hardest case to reach from the ports is a configuration change or a second start that lands in the middle of a transfer. To prove the change is ignored, the stimulus must arrive after the frame has begun and be visible at the edges that follow. The bench starts a 16-bit mode 0 transfer with a slow divider. Ten clocks later it switches to mode 3, LSB-first order and the fastest divider, and pulses start with a different word. It then checks three things: the SCK timing and the bit stream seen by its slave model still match the original settings, the readback holds during busy, and the new settings appear only afterwards. Sampling and drive edges are measured separately for each mode by a slave model that reacts to SCK itself. This exposes any off-by-one-tick error around the chip-select edges.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'd0,
        SZ_HALF     = 2'd1,
        SZ_WORD     = 2'd2,
        SZ_WORD_ALT = 2'd3
    } xfer_size_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_ACT,
        PH_REST,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
        logic big_endian;
    } wire_fmt_t;

    // Field layout of the packed divider word
    localparam int DIV_PRE_LSB = 0;
    localparam int DIV_PRE_W   = 16;
    localparam int DIV_CNT_LSB = 16;
    localparam int DIV_CNT_W   = 8;

    // Index of the most significant byte lane for a transfer width
    function automatic logic [1:0] top_lane(xfer_size_e sz);
        case (sz)
            SZ_BYTE: return 2'd0;
            SZ_HALF: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [4:0] last_slot(xfer_size_e sz);
        return {top_lane(sz), 3'b111};
    endfunction

    // Serial slot number -> bit position inside the parallel word
    function automatic logic [4:0] slot_to_bit(logic [4:0] slot, xfer_size_e sz,
                                               logic lsb, logic big);
        logic [1:0] lane;
        logic [2:0] pos;
        lane = big ? (top_lane(sz) - slot[4:3]) : slot[4:3];
        pos  = lsb ? slot[2:0] : ~slot[2:0];
        return {lane, pos};
    endfunction

endpackage

// File: rtl/spi_wm_prescaler.sv
module spi_wm_prescaler #(
    parameter int PRE_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] pre_m1,
    output logic             tick
);
    logic [PRE_W-1:0] pre_cnt;

    assign tick = run && (pre_cnt == pre_m1);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R2: consecutive ticks only when the prescaler is 1
    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && pre_m1 != '0) |=> !tick);

endmodule

// File: rtl/spi_wm_sequencer.sv
module spi_wm_sequencer
    import spi_wm_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_ok,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_m1,
    input  logic             cpol,
    input  logic             last_now,
    output logic             busy,
    output logic             done,
    output logic             sck,
    output logic             cs_n,
    output logic             lead_ev,
    output logic             trail_ev
);
    phase_e         state;
    logic [CNT_W:0] tcnt;
    logic [CNT_W:0] period;
    logic [CNT_W:0] hi_len;
    logic [CNT_W:0] lo_len;
    logic           hi_end;
    logic           lo_end;

    always_comb begin
        period = {1'b0, cnt_m1} + 1'b1;
        hi_len = period >> 1;
        lo_len = period - hi_len;
        hi_end = (tcnt == hi_len - 1'b1);
        lo_end = (tcnt == lo_len - 1'b1);
    end

    assign busy     = (state != PH_IDLE);
    assign lead_ev  = tick && ((state == PH_LEAD) || (state == PH_REST && lo_end));
    assign trail_ev = tick && (state == PH_ACT) && hi_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            tcnt  <= '0;
            sck   <= 1'b0;
            cs_n  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                PH_IDLE: begin
                    sck  <= cpol;
                    tcnt <= '0;
                    if (start_ok) begin
                        state <= PH_LEAD;
                        cs_n  <= 1'b0;
                    end
                end
                PH_LEAD: begin
                    if (lead_ev) begin
                        sck   <= ~cpol;
                        state <= PH_ACT;
                        tcnt  <= '0;
                    end
                end
                PH_ACT: begin
                    if (trail_ev) begin
                        sck   <= cpol;
                        tcnt  <= '0;
                        state <= last_now ? PH_TAIL : PH_REST;
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                PH_REST: begin
                    if (lead_ev) begin
                        sck   <= ~cpol;
                        tcnt  <= '0;
                        state <= PH_ACT;
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                PH_TAIL: begin
                    if (tick) begin
                        cs_n  <= 1'b1;
                        done  <= 1'b1;
                        state <= PH_IDLE;
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    sck_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(sck));

    // R9
    tail_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PH_TAIL && tick) |=> (done && cs_n && !busy));

    // R9
    frame_select_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && state != PH_LEAD) |-> !cs_n);

endmodule

// File: rtl/spi_wm_shifter.sv
module spi_wm_shifter
    import spi_wm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_ok,
    input  logic        lead_ev,
    input  logic        trail_ev,
    input  logic        done,
    input  wire_fmt_t   fmt,
    input  xfer_size_e  size,
    input  logic [31:0] tx_word,
    input  logic        miso,
    output logic        mosi,
    output logic [31:0] rx_word,
    output logic        last_now
);
    logic [31:0] tx_q;
    logic [31:0] rx_q;
    logic [4:0]  slot;
    xfer_size_e  size_q;
    logic [4:0]  cur_bit;
    logic [4:0]  nxt_bit;
    logic [4:0]  first_bit;

    always_comb begin
        cur_bit   = slot_to_bit(slot, size_q, fmt.lsb_first, fmt.big_endian);
        nxt_bit   = slot_to_bit(slot + 5'd1, size_q, fmt.lsb_first, fmt.big_endian);
        first_bit = slot_to_bit(5'd0, size, fmt.lsb_first, fmt.big_endian);
        last_now  = (slot == last_slot(size_q));
    end

    assign rx_word = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            rx_q   <= '0;
            slot   <= '0;
            size_q <= SZ_BYTE;
            mosi   <= 1'b0;
        end else if (start_ok) begin
            tx_q   <= tx_word;
            rx_q   <= '0;
            slot   <= '0;
            size_q <= size;
            mosi   <= fmt.cpha ? 1'b0 : tx_word[first_bit];
        end else begin
            if (lead_ev) begin
                if (fmt.cpha) mosi <= tx_q[cur_bit];
                else          rx_q[cur_bit] <= miso;
            end
            if (trail_ev) begin
                if (fmt.cpha) rx_q[cur_bit] <= miso;
                if (!last_now) begin
                    slot <= slot + 5'd1;
                    if (!fmt.cpha) mosi <= tx_q[nxt_bit];
                end
            end
            if (done) mosi <= 1'b0;
        end
    end

    // R8
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot <= last_slot(size_q));

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spi_wm_pkg::*;
#(
    parameter int PRE_W = 13,
    parameter int CNT_W = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_mode,
    input  logic        cfg_lsb_first,
    input  logic        cfg_big_endian,
    input  logic [31:0] cfg_div,
    input  logic        start,
    input  logic [1:0]  size,
    input  logic [31:0] tx_word,
    output logic        busy,
    output logic        done,
    output logic [31:0] rx_word,
    output logic [1:0]  rb_mode,
    output logic        rb_lsb_first,
    output logic        rb_big_endian,
    output logic [31:0] rb_div,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n
);
    localparam int PRE_MAX = 1 << PRE_W;
    localparam int CNT_MAX = 1 << CNT_W;

    wire_fmt_t               fmt_in, fmt_q, fmt_use;
    logic [PRE_W-1:0]        pre_in, pre_q, pre_use;
    logic [CNT_W-1:0]        cnt_in, cnt_q, cnt_use;
    logic [DIV_PRE_W-1:0]    pre_raw;
    logic [DIV_CNT_W-1:0]    cnt_raw;
    logic                    start_ok;
    logic                    tick;
    logic                    lead_ev, trail_ev, last_now;

    // Decode and clamp the live configuration
    always_comb begin
        fmt_in.cpol       = cfg_mode[1];
        fmt_in.cpha       = cfg_mode[0];
        fmt_in.lsb_first  = cfg_lsb_first;
        fmt_in.big_endian = cfg_big_endian;
        pre_raw = cfg_div[DIV_PRE_LSB +: DIV_PRE_W];
        cnt_raw = cfg_div[DIV_CNT_LSB +: DIV_CNT_W];
        if (pre_raw == '0)
            pre_in = '0;
        else if (32'(pre_raw) > PRE_MAX)
            pre_in = PRE_W'(PRE_MAX - 1);
        else
            pre_in = PRE_W'(pre_raw - 1'b1);
        if (cnt_raw < DIV_CNT_W'(2))
            cnt_in = CNT_W'(1);
        else if (32'(cnt_raw) > CNT_MAX)
            cnt_in = CNT_W'(CNT_MAX - 1);
        else
            cnt_in = CNT_W'(cnt_raw - 1'b1);
    end

    // Settings follow the inputs while idle and freeze during a frame
    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q <= '0;
            pre_q <= '0;
            cnt_q <= CNT_W'(1);
        end else if (!busy) begin
            fmt_q <= fmt_in;
            pre_q <= pre_in;
            cnt_q <= cnt_in;
        end
    end

    assign fmt_use  = busy ? fmt_q : fmt_in;
    assign pre_use  = busy ? pre_q : pre_in;
    assign cnt_use  = busy ? cnt_q : cnt_in;
    assign start_ok = start && !busy;

    always_comb begin
        rb_div = '0;
        rb_div[DIV_PRE_LSB +: DIV_PRE_W] = DIV_PRE_W'(pre_q) + 1'b1;
        rb_div[DIV_CNT_LSB +: DIV_CNT_W] = DIV_CNT_W'(cnt_q) + 1'b1;
    end
    assign rb_mode       = {fmt_q.cpol, fmt_q.cpha};
    assign rb_lsb_first  = fmt_q.lsb_first;
    assign rb_big_endian = fmt_q.big_endian;

    spi_wm_prescaler #(.PRE_W(PRE_W)) u_prescaler (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .pre_m1 (pre_use),
        .tick   (tick)
    );

    spi_wm_sequencer #(.CNT_W(CNT_W)) u_sequencer (
        .clk      (clk),
        .rst      (rst),
        .start_ok (start_ok),
        .tick     (tick),
        .cnt_m1   (cnt_use),
        .cpol     (fmt_use.cpol),
        .last_now (last_now),
        .busy     (busy),
        .done     (done),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .lead_ev  (lead_ev),
        .trail_ev (trail_ev)
    );

    spi_wm_shifter u_shifter (
        .clk      (clk),
        .rst      (rst),
        .start_ok (start_ok),
        .lead_ev  (lead_ev),
        .trail_ev (trail_ev),
        .done     (done),
        .fmt      (fmt_use),
        .size     (xfer_size_e'(size)),
        .tx_word  (tx_word),
        .miso     (spi_miso),
        .mosi     (spi_mosi),
        .rx_word  (rx_word),
        .last_now (last_now)
    );

    // R11
    cfg_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable({rb_mode, rb_lsb_first, rb_big_endian, rb_div}));

    // R9
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !spi_cs_n));

    // R1
    idle_select_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> spi_cs_n);

endmodule

// File: tb/test_spi_word_master.sv
`timescale 1ns/1ps
module test_spi_word_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_lsb_first = 1'b0;
    logic        cfg_big_endian = 1'b0;
    logic [31:0] cfg_div = 32'h0002_0001;
    logic        start = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [31:0] tx_word = '0;
    logic        busy, done;
    logic [31:0] rx_word;
    logic [1:0]  rb_mode;
    logic        rb_lsb_first, rb_big_endian;
    logic [31:0] rb_div;
    logic        spi_sck, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;

    // expectations of the current transfer
    logic        cpol_t, cpha_t;
    int          nbits_t, pre_t, cnt_t;
    logic [31:0] exp_tx_bits, slv_bits, cap_bits, exp_rx;
    int          nlead, ntrail;
    longint      lead_t [32];
    longint      trail_t[32];
    longint      t_start, t_done, t_csfall, t_csrise;

    always #4 clk = ~clk;

    spi_word_master i_spi_word_master (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_lsb_first(cfg_lsb_first),
        .cfg_big_endian(cfg_big_endian), .cfg_div(cfg_div), .start(start), .size(size),
        .tx_word(tx_word), .busy(busy), .done(done), .rx_word(rx_word), .rb_mode(rb_mode),
        .rb_lsb_first(rb_lsb_first), .rb_big_endian(rb_big_endian), .rb_div(rb_div),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // Slave model
    always @(negedge spi_cs_n) begin
        t_csfall = $time;
        nlead = 0;
        ntrail = 0;
        cap_bits = '0;
        if (!cpha_t) spi_miso = slv_bits[0];
    end

    always @(posedge spi_cs_n) t_csrise = $time;

    always @(spi_sck) begin
        if (!spi_cs_n) begin
            if (spi_sck != cpol_t) begin
                if (nlead < 32) lead_t[nlead] = $time;
                nlead = nlead + 1;
                if (!cpha_t) begin
                    if (nlead <= 32) cap_bits[nlead-1] = spi_mosi;
                end else begin
                    if (nlead <= 32) spi_miso = slv_bits[nlead-1];
                end
            end else begin
                if (ntrail < 32) trail_t[ntrail] = $time;
                ntrail = ntrail + 1;
                if (!cpha_t) begin
                    if (nlead < 32) spi_miso = slv_bits[nlead];
                end else begin
                    if (nlead >= 1 && nlead <= 32) cap_bits[nlead-1] = spi_mosi;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Serial slot -> word bit, from the bit- and byte-order requirements
    function automatic int slot_bit(int i, int nbytes, bit lsb, bit big);
        int byte_sel, bit_sel;
        byte_sel = big ? (nbytes - 1 - i / 8) : (i / 8);
        bit_sel  = lsb ? (i % 8) : (7 - i % 8);
        return byte_sel * 8 + bit_sel;
    endfunction

    task automatic setup(input int mode, input bit lsb, input bit big, input int pre,
                         input int cnt, input int sz, input logic [31:0] tx,
                         input logic [31:0] slv);
        int nbytes;
        cfg_mode = 2'(mode);
        cfg_lsb_first = lsb;
        cfg_big_endian = big;
        cfg_div = {8'h00, 8'(cnt), 16'(pre)};
        size = 2'(sz);
        tx_word = tx;
        cpol_t = mode[1];
        cpha_t = mode[0];
        pre_t = (pre == 0) ? 1 : pre;
        cnt_t = (cnt < 2) ? 2 : cnt;
        nbytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        nbits_t = nbytes * 8;
        exp_tx_bits = '0;
        slv_bits = '0;
        exp_rx = '0;
        for (int i = 0; i < nbits_t; i++) begin
            exp_tx_bits[i] = tx[slot_bit(i, nbytes, lsb, big)];
            slv_bits[i]    = slv[slot_bit(i, nbytes, lsb, big)];
            exp_rx[slot_bit(i, nbytes, lsb, big)] = slv[slot_bit(i, nbytes, lsb, big)];
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic launch();
        @(negedge clk);
        start = 1'b1;
        t_start = $time + 4;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
        t_done = $time - 4;
    endtask

    task automatic check_xfer(input string req);
        longint p;
        p = 8 * pre_t;
        chk(rx_word == exp_rx, req, "rx_word", rx_word, exp_rx);
        chk(cap_bits == exp_tx_bits, req, "mosi stream", cap_bits, exp_tx_bits);
        chk(nlead == nbits_t, "R8", "sck cycles", nlead, nbits_t);
        chk(t_csfall == t_start, "R9", "cs fall time", t_csfall, t_start);
        chk(lead_t[0] - t_start == p, "R9", "first edge delay", lead_t[0] - t_start, p);
        chk(trail_t[0] - lead_t[0] == p * (cnt_t / 2), "R2", "active phase",
            trail_t[0] - lead_t[0], p * (cnt_t / 2));
        chk(lead_t[1] - lead_t[0] == p * cnt_t, "R2", "sck period",
            lead_t[1] - lead_t[0], p * cnt_t);
        chk(t_done - trail_t[nbits_t-1] == p, "R9", "tail delay",
            t_done - trail_t[nbits_t-1], p);
        chk(t_csrise == t_done, "R9", "cs rise time", t_csrise, t_done);
        chk(busy == 1'b0, "R9", "busy after done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done width", done, 0);
    endtask

    task automatic test_reset();
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(done == 0, "R1", "done", done, 0);
        chk(spi_cs_n == 1, "R1", "cs_n", spi_cs_n, 1);
        chk(spi_sck == 0, "R1", "sck", spi_sck, 0);
        chk(spi_mosi == 0, "R1", "mosi", spi_mosi, 0);
        chk(rx_word == 0, "R1", "rx_word", rx_word, 0);
    endtask

    task automatic test_modes();
        for (int m = 0; m < 4; m++) begin
            setup(m, 0, 0, 2, 4, 0, 32'hA5 ^ m, 32'h3C + m);
            chk(spi_sck == m[1], "R4", "idle sck", spi_sck, m[1]);
            chk(rb_mode == 2'(m), "R4", "rb_mode", rb_mode, m);
            launch();
            wait_done();
            check_xfer("R5");
        end
    endtask

    task automatic test_orders();
        for (int k = 0; k < 4; k++) begin
            setup((k == 2) ? 3 : 0, k[0], k[1], 1, 2, 1, 32'h0000_81C3, 32'h0000_6E17);
            chk(rb_lsb_first == k[0], "R6", "rb_lsb_first", rb_lsb_first, k[0]);
            chk(rb_big_endian == k[1], "R7", "rb_big_endian", rb_big_endian, k[1]);
            launch();
            wait_done();
            check_xfer(k[0] ? "R6" : "R7");
            setup((k == 1) ? 1 : 2, k[0], k[1], 1, 3, 2, 32'h1234_5678, 32'hC0FF_EE42);
            launch();
            wait_done();
            check_xfer(k[1] ? "R7" : "R6");
        end
        // byte order has no effect on a single byte
        setup(0, 0, 1, 1, 2, 0, 32'h0000_0096, 32'h0000_004B);
        launch();
        wait_done();
        check_xfer("R7");
    endtask

    task automatic test_divider();
        setup(0, 0, 0, 8, 10, 0, 32'h5A, 32'hC3);
        launch(); wait_done(); check_xfer("R2");
        setup(1, 0, 0, 5, 2, 0, 32'hF0, 32'h0F);
        launch(); wait_done(); check_xfer("R2");
        setup(2, 1, 0, 3, 5, 0, 32'h21, 32'h84);
        launch(); wait_done(); check_xfer("R2");
    endtask

    task automatic test_sizes();
        setup(0, 0, 1, 1, 2, 1, 32'hFFFF_ABCD, 32'hFFFF_FFFF);
        launch(); wait_done(); check_xfer("R8");
        chk(rx_word[31:16] == 0, "R8", "rx upper bits", rx_word[31:16], 0);
        setup(3, 1, 1, 1, 2, 3, 32'hDEAD_BEEF, 32'h0BAD_F00D);
        launch(); wait_done(); check_xfer("R8");
        setup(0, 0, 0, 1, 2, 0, 32'hFFFF_FF77, 32'hFFFF_FFFF);
        launch(); wait_done(); check_xfer("R8");
        chk(rx_word[31:8] == 0, "R8", "rx upper bits 8", rx_word[31:8], 0);
    endtask

    task automatic test_clamp();
        cfg_div = 32'h0000_0000;
        repeat (2) @(negedge clk);
        chk(rb_div == 32'h0002_0001, "R3", "zero fields", rb_div, 32'h0002_0001);
        cfg_div = 32'h0001_2328; // prescaler 9000, count 1
        repeat (2) @(negedge clk);
        chk(rb_div == 32'h0002_2000, "R3", "high prescaler", rb_div, 32'h0002_2000);
        cfg_div = 32'h00C8_2000; // count 200, prescaler 8192
        repeat (2) @(negedge clk);
        chk(rb_div == 32'h0040_2000, "R3", "high count", rb_div, 32'h0040_2000);
        cfg_div = 32'h0040_1FFF;
        repeat (2) @(negedge clk);
        chk(rb_div == 32'h0040_1FFF, "R3", "in range", rb_div, 32'h0040_1FFF);
        // clamped timing: prescaler 0 and count 1 act as 1 and 2
        setup(0, 0, 0, 0, 1, 0, 32'h69, 32'h96);
        chk(rb_div == 32'h0002_0001, "R3", "clamped readback", rb_div, 32'h0002_0001);
        launch(); wait_done(); check_xfer("R3");
    endtask

    task automatic test_busy_ignore();
        setup(0, 0, 0, 2, 4, 1, 32'h0000_A1B2, 32'h0000_7E81);
        launch();
        repeat (10) @(negedge clk);
        cfg_mode = 2'd3;
        cfg_lsb_first = 1'b1;
        cfg_big_endian = 1'b1;
        cfg_div = 32'h0002_0001;
        tx_word = 32'h0000_FFFF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1, "R10", "still busy", busy, 1);
        chk(rb_mode == 0, "R11", "rb_mode held", rb_mode, 0);
        chk(rb_lsb_first == 0, "R11", "rb_lsb_first held", rb_lsb_first, 0);
        chk(rb_div == 32'h0004_0002, "R11", "rb_div held", rb_div, 32'h0004_0002);
        wait_done();
        check_xfer("R11");
        repeat (3) @(negedge clk);
        chk(busy == 0 && spi_cs_n == 1, "R10", "no second frame", {busy, spi_cs_n}, 1);
        chk(rb_mode == 3, "R11", "rb_mode after", rb_mode, 3);
        chk(rb_div == 32'h0002_0001, "R11", "rb_div after", rb_div, 32'h0002_0001);
        chk(spi_sck == 1, "R4", "idle sck after mode change", spi_sck, 1);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cpol_t = 0; cpha_t = 0; nbits_t = 8; pre_t = 1; cnt_t = 2;
        slv_bits = '0; cap_bits = '0; nlead = 0; ntrail = 0;
        repeat (4) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_modes();
        test_orders();
        test_divider();
        test_sizes();
        test_clamp();
        test_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule